// File: doc/BRIEF.md
# Phase-Switching Multimodulus Prescaler

This block divides a fast input clock by a programmable modulus between 64 and 71. A two-bit toggle stage (a master and a slave latch bit clocked on alternate values) produces four quarter-rate phases, each lagging the one before it by exactly one input clock. A pointer picks one of these phases, and a sixteen-step counter advances on each rising edge of the picked phase, which gives a base ratio of 4 x 16 = 64.

To stretch an output period by one input clock, the pointer moves to the next lagging phase, so the next rising edge of the picked phase arrives five input clocks after the last instead of four. A 3-bit mode word M is captured once per output period, and that many forward moves are made early in the period, one per quarter-rate edge. The divided clock and a one-cycle period-start strobe are the outputs. Fast paths are the same as those of a fixed divide-by-64: the mode word reaches only a small down-counter.

Top module: `phase_switch_prescaler`

## Requirements
- R1: In the first clock cycle after a synchronous reset is released, both `cycleStart` and `divOut` are 1, and the first output period begins in that cycle using the mode value present then.
- R2: The number of input clock cycles from one `cycleStart` pulse to the next equals 64 + M, where M is the unsigned value of `mode` in the cycle in which the first of the two pulses was high.
- R3: With M = 0 the period is exactly 64 input clocks (no phase moves).
- R4: With M = 7 the period is exactly 71 input clocks.
- R5: A change of `mode` in any cycle other than a `cycleStart` cycle has no effect on the period in progress; it applies from the period that starts after the next `cycleStart` cycle in which it is present.
- R6: `divOut` rises only in a `cycleStart` cycle, stays 1 for 32 + M cycles counted from that cycle, then stays 0 for 32 cycles.
- R7: `cycleStart` is high for exactly one cycle per output period and never in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 3 | Extra input periods per output period (0 to 7) |
| divOut | output | 1 | Divided clock |
| cycleStart | output | 1 | One-cycle strobe marking the first cycle of each output period |

## Verification
The hardest situation to reach is a mode word that changes while phase moves for the current period are still being issued, because it must neither cut short nor extend the moves already scheduled. The stimulus changes the mode at several offsets inside a running period, including shortly after the strobe while moves are pending, and the per-cycle reference model, which only latches the mode at the strobe, predicts each following period length and output level. Every modulus from 64 to 71 is run for several consecutive periods, and a reset in the middle of a run checks that the first period after release is full length.

// File: rtl/psw_pkg.sv
`timescale 1ns/1ps
package psw_pkg;
  // Control to datapath: request to move the phase pointer forward.
  typedef struct packed {
    logic phaseStep;
  } pswCtrl_t;

  // Datapath to control: timing strobes.
  typedef struct packed {
    logic lateTick;     // cycle after a selected-phase rising edge
    logic periodStart;  // first cycle of an output period
  } pswStat_t;
endpackage

// File: rtl/psw_datapath.sv
`timescale 1ns/1ps
module psw_datapath
  import psw_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  pswCtrl_t   ctrl,
  output pswStat_t   stat,
  output logic [1:0] phasePtr,
  output logic       divOut,
  output logic       cycleStart
);
  localparam int NPH = 4;

  logic             master;
  logic             slave;
  logic [NPH-1:0]   phaseVec;
  logic [CNT_W-1:0] edgeCnt;
  logic [1:0]       nextPtr;
  logic             tick;
  logic             wrapTick;
  logic             lateTick;

  // Quarter-rate toggle stage: master/slave pair counting in Johnson order.
  always_ff @(posedge clk) begin
    if (rst) begin
      master <= 1'b1;
      slave  <= 1'b1;
    end else begin
      master <= ~slave;
      slave  <= master;
    end
  end

  // Four quadrature phases, each one input clock behind the previous.
  for (genvar k = 0; k < NPH; k++) begin : g_phase
    if (k == 0) begin : g_m
      assign phaseVec[k] = master;
    end else if (k == 1) begin : g_s
      assign phaseVec[k] = slave;
    end else begin : g_inv
      assign phaseVec[k] = ~phaseVec[k-2];
    end
  end

  // Rising edge of the selected phase: it is high while its lagging neighbour is still low.
  assign nextPtr  = phasePtr + 2'd1;
  assign tick     = phaseVec[phasePtr] & ~phaseVec[nextPtr];
  assign wrapTick = tick && (edgeCnt == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      phasePtr   <= 2'd0;
      edgeCnt    <= '0;
      lateTick   <= 1'b1;
      cycleStart <= 1'b1;
    end else begin
      if (ctrl.phaseStep) phasePtr <= nextPtr;
      if (tick) edgeCnt <= edgeCnt + 1'b1;
      lateTick   <= tick;
      cycleStart <= wrapTick;
    end
  end

  assign divOut            = ~edgeCnt[CNT_W-1];
  assign stat.lateTick     = lateTick;
  assign stat.periodStart  = cycleStart;
endmodule

// File: rtl/psw_control.sv
`timescale 1ns/1ps
module psw_control
  import psw_pkg::*;
#(
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  input  pswStat_t          stat,
  output pswCtrl_t          ctrl
);
  logic [MODE_W-1:0] movesLeft;

  // One move per quarter-rate edge, issued the cycle after that edge.
  assign ctrl.phaseStep = (movesLeft != '0) && stat.lateTick;

  always_ff @(posedge clk) begin
    if (rst) begin
      movesLeft <= '0;
    end else if (stat.periodStart) begin
      movesLeft <= mode;
    end else if (ctrl.phaseStep) begin
      movesLeft <= movesLeft - 1'b1;
    end
  end
endmodule

// File: rtl/phase_switch_prescaler.sv
`timescale 1ns/1ps
module phase_switch_prescaler
  import psw_pkg::*;
#(
  parameter int MODE_W = 3,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  output logic              divOut,
  output logic              cycleStart
);
  pswCtrl_t   ctrlBus;
  pswStat_t   statBus;
  logic [1:0] phasePtr;

  psw_control #(.MODE_W(MODE_W)) uCtrl (
    .clk  (clk),
    .rst  (rst),
    .mode (mode),
    .stat (statBus),
    .ctrl (ctrlBus)
  );

  psw_datapath #(.CNT_W(CNT_W)) uDp (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrlBus),
    .stat       (statBus),
    .phasePtr   (phasePtr),
    .divOut     (divOut),
    .cycleStart (cycleStart)
  );
endmodule

// File: rtl/psw_checker.sv
`timescale 1ns/1ps
module psw_checker #(
  parameter int MODE_W = 3,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [MODE_W-1:0] mode,
  input logic              divOut,
  input logic              cycleStart,
  input logic [1:0]        phasePtr
);
  localparam int BASE  = 4 * (1 << CNT_W);
  localparam int LEN_W = CNT_W + 4;

  logic [LEN_W-1:0] elapsed;
  logic [LEN_W-1:0] expLen;
  logic             armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      elapsed <= '0;
      expLen  <= '0;
      armed   <= 1'b0;
    end else if (cycleStart) begin
      elapsed <= LEN_W'(1);
      expLen  <= LEN_W'(BASE) + LEN_W'(mode);
      armed   <= 1'b1;
    end else begin
      elapsed <= elapsed + 1'b1;
    end
  end

  // R1
  reset_release_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cycleStart && divOut));

  // R2
  period_len_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> (cycleStart == (elapsed == expLen)));

  // R2
  ptr_forward_chk: assert property (@(posedge clk) disable iff (rst)
    (phasePtr == $past(phasePtr)) || (phasePtr == $past(phasePtr) + 2'd1));

  // R6
  out_high_at_start_chk: assert property (@(posedge clk) disable iff (rst)
    cycleStart |-> divOut);

  // R6
  rise_only_at_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(divOut) |-> cycleStart);

  // R7
  single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    cycleStart |=> !cycleStart);
endmodule

bind phase_switch_prescaler psw_checker #(.MODE_W(MODE_W), .CNT_W(CNT_W)) uChk (
  .clk        (clk),
  .rst        (rst),
  .mode       (mode),
  .divOut     (divOut),
  .cycleStart (cycleStart),
  .phasePtr   (phasePtr)
);

// File: tb/tb_phase_switch_prescaler.sv
`timescale 1ns/1ps
module tb_phase_switch_prescaler;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] mode = 3'd0;
  logic       divOut;
  logic       cycleStart;

  int    checks = 0;
  int    errors = 0;
  string curTag = "R2";
  bit    done   = 1'b0;

  // reference model state
  bit firstCyc  = 1'b1;
  bit prevStart = 1'b0;
  int elapsed   = 0;
  int mLat      = 0;

  always #2 clk = ~clk;

  phase_switch_prescaler dut (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .divOut     (divOut),
    .cycleStart (cycleStart)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: count clocks since the period start, latch mode at each start.
  always @(negedge clk) begin
    if (rst) begin
      firstCyc  = 1'b1;
      prevStart = 1'b0;
    end else begin
      if (firstCyc) begin
        chk(cycleStart == 1'b1, "R1", "cycleStart after reset", int'(cycleStart), 1);
        chk(divOut == 1'b1, "R1", "divOut after reset", int'(divOut), 1);
        elapsed  = 0;
        mLat     = int'(mode);
        firstCyc = 1'b0;
      end else begin
        bit expStart;
        elapsed++;
        expStart = (elapsed == 64 + mLat);
        chk(cycleStart == expStart, curTag, "cycleStart vs period 64+M", int'(cycleStart), int'(expStart));
        if (expStart) begin
          elapsed = 0;
          mLat    = int'(mode);
        end
        chk(divOut == (elapsed < 32 + mLat), "R6", "divOut level",
            int'(divOut), int'(elapsed < 32 + mLat));
      end
      if (cycleStart)
        chk(!prevStart, "R7", "strobe in consecutive cycles", int'(prevStart), 0);
      prevStart = cycleStart;
    end
  end

  task automatic waitStarts(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!cycleStart) @(negedge clk);
    end
  endtask

  task automatic setMode(input int m);
    @(posedge clk);
    #1 mode = 3'(m);
  endtask

  task automatic doReset(input int m);
    @(posedge clk);
    #1 rst = 1'b1;
    mode = 3'(m);
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  initial begin
    // R1: reset state and first period
    curTag = "R1";
    mode = 3'd3;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    waitStarts(3);

    // R2, R3, R4: every modulus, several periods each
    for (int m = 0; m < 8; m++) begin
      curTag = (m == 0) ? "R3" : (m == 7) ? "R4" : "R2";
      setMode(m);
      waitStarts(4);
    end

    // R5: mode changes inside running periods, including while moves are pending
    curTag = "R5";
    setMode(2);
    waitStarts(2);
    repeat (3) @(posedge clk);
    #1 mode = 3'd7;
    repeat (20) @(posedge clk);
    #1 mode = 3'd0;
    waitStarts(1);
    repeat (40) @(posedge clk);
    #1 mode = 3'd5;
    repeat (10) @(posedge clk);
    #1 mode = 3'd1;
    waitStarts(3);
    setMode(6);
    @(posedge clk);
    #1 mode = 3'd4;
    waitStarts(3);

    // R1: reset in the middle of a period
    curTag = "R1";
    repeat (17) @(posedge clk);
    doReset(7);
    curTag = "R4";
    waitStarts(3);

    done = 1'b1;
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule